// File: doc/BRIEF.md
# UART Interrupt Priority Encoder

This block sits beside one UART channel and merges seven separate interrupt-request conditions into a single 8-bit interrupt status value. Each raw request is first gated by its own enable bit. Among the enabled requests that are active, the one with the highest priority is encoded as a fixed 6-bit code. The value also carries an active-low "pending" flag in bit 0 and a FIFO-enable indication in bits 7:6. An interrupt output follows the pending flag.

The status value is registered. A read of the status register arrives as a one-cycle strobe. The value is frozen for the cycle of the strobe, so software sees a consistent code. For sources that clear on read, the block issues a one-cycle clear pulse back to the source's own logic. The pulse is issued only when that source is the one encoded in the value being read.

Source index (used on `req_i`, `en_i`, `clr_o`), highest priority first: 0 receiver line status, 1 received data ready, 2 receive data time-out, 3 transmit holding empty, 4 modem status, 5 flow-control or special character received, 6 flow-control pin change of state.

Top module: `uart_irq_prio`

## Requirements
- R1: When several enabled requests are active, only the source with the lowest index is encoded. A source with a higher index is shown only after every lower-index source has dropped.
- R2: `status_o[5:0]` is 000110 for source 0, 000100 for source 1, 001100 for source 2, 000010 for source 3 and 000000 for source 4.
- R3: `status_o[5:0]` is 010000 for source 5 and 100000 for source 6.
- R4: `status_o[0]` is 0 while any enabled request is encoded and 1 when none is. With no enabled request, `status_o[5:0]` is 000001. During and right after reset, `status_o` is 8'h01.
- R5: `status_o[7:6]` are both 1 when `fifo_en_i` is 1 and both 0 when it is 0.
- R6: A request whose `en_i` bit is 0 never appears in the code and never makes an interrupt pending.
- R7: In a cycle with `rd_stb_i` high, `status_o` and `irq_o` do not change at the following clock edge. Otherwise they take the value computed from the inputs at that edge (one clock of latency).
- R8: `clr_o[i]` is high only while `rd_stb_i` is high, source i is clear-on-read (by default only source 3), and the registered status currently encodes source i. At most one bit of `clr_o` is high at a time.
- R9: `irq_o` is 1 exactly when `status_o[0]` is 0. It changes one clock after the enabled requests change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 7 | Raw interrupt requests, index 0 highest priority |
| en_i | input | 7 | Per-source enables |
| fifo_en_i | input | 1 | FIFO mode enabled |
| rd_stb_i | input | 1 | Status register read strobe |
| status_o | output | 8 | Registered interrupt status value |
| irq_o | output | 1 | Interrupt request, active high |
| clr_o | output | 7 | Clear pulse to clear-on-read sources |

## Verification
The read strobe and a change of request can fall in the same cycle. The bench provokes this by raising a higher-priority request in the same cycle as the strobe while the transmit-empty code is shown. It judges the result in three ways. The clear pulse must name transmit-empty during that cycle. The status must keep the old code across the edge. The new code must appear one edge after the strobe drops. A second strobe is then issued while the line-status code is shown, and no clear pulse may appear.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 7;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);
  localparam logic [5:0]  CODE_NONE = 6'b000001;

  function automatic logic [5:0] src_code(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    src_code = 6'b000110;
      3'd1:    src_code = 6'b000100;
      3'd2:    src_code = 6'b001100;
      3'd3:    src_code = 6'b000010;
      3'd4:    src_code = 6'b000000;
      3'd5:    src_code = 6'b010000;
      3'd6:    src_code = 6'b100000;
      default: src_code = CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_gate.sv
module uart_irq_gate #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] act_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign act_o[i] = req_i[i] & en_i[i];
  end
endmodule

// File: rtl/uart_irq_find.sv
module uart_irq_find #(
  parameter int unsigned N     = 7,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: scan from top down so the last hit is the lowest
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] CLR_ON_READ = 7'b0001000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               fifo_en_i,
  input  logic               rd_stb_i,
  output logic [7:0]         status_o,
  output logic               irq_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic [NUM_SRC-1:0] act;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [7:0]         status_d, status_q;
  logic               irq_q, shown_vld_q;
  logic [IDX_W-1:0]   shown_idx_q;

  uart_irq_gate #(.N(NUM_SRC)) u_gate (
    .req_i (req_i),
    .en_i  (en_i),
    .act_o (act)
  );

  uart_irq_find #(.N(NUM_SRC), .IDX_W(IDX_W)) u_find (
    .act_i   (act),
    .valid_o (hit),
    .idx_o   (hit_idx)
  );

  assign status_d = {fifo_en_i, fifo_en_i, hit ? src_code(hit_idx) : CODE_NONE};

  // frozen during a read so the value read and the clear decision agree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= {2'b00, CODE_NONE};
      irq_q       <= 1'b0;
      shown_vld_q <= 1'b0;
      shown_idx_q <= '0;
    end else if (!rd_stb_i) begin
      status_q    <= status_d;
      irq_q       <= hit;
      shown_vld_q <= hit;
      shown_idx_q <= hit_idx;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    if (CLR_ON_READ[i]) begin : g_cor
      assign clr_o[i] = rd_stb_i & shown_vld_q & (shown_idx_q == IDX_W'(i));
    end else begin : g_keep
      assign clr_o[i] = 1'b0;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/uart_irq_prio_chk.sv
module uart_irq_prio_chk
  import uart_irq_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rd_stb_i,
  input logic [7:0]         status_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] clr_o
);
  p_irq_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !status_o[0]);

  p_hold_on_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stb_i |=> $stable(status_o) && $stable(irq_o));

  p_clr_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));

  p_clr_needs_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_o != '0) |-> rd_stb_i && !status_o[0]);

  p_idle_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] |-> status_o[5:1] == 5'd0);

  p_fifo_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7] == status_o[6]);
endmodule

bind uart_irq_prio uart_irq_prio_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_stb_i (rd_stb_i),
  .status_o (status_o),
  .irq_o    (irq_o),
  .clr_o    (clr_o)
);

// File: tb/uart_irq_prio_bench.sv
module uart_irq_prio_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] req_i = '0;
  logic [6:0] en_i = '0;
  logic       fifo_en_i = 1'b0;
  logic       rd_stb_i = 1'b0;
  logic [7:0] status_o;
  logic       irq_o;
  logic [6:0] clr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  uart_irq_prio u_uart_irq_prio (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .en_i(en_i),
    .fifo_en_i(fifo_en_i), .rd_stb_i(rd_stb_i),
    .status_o(status_o), .irq_o(irq_o), .clr_o(clr_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  // {req[6:0], en[6:0], fifo, expected status}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {7'b0000000, 7'h7F, 1'b0, 8'h01},  // R4 idle
    {7'b1111111, 7'h7F, 1'b1, 8'hC6},  // R1 R2 R5 line status wins
    {7'b1111110, 7'h7F, 1'b1, 8'hC4},  // R1 R2 data ready
    {7'b1111100, 7'h7F, 1'b1, 8'hCC},  // R2 time-out
    {7'b1111000, 7'h7F, 1'b1, 8'hC2},  // R2 tx empty
    {7'b1110000, 7'h7F, 1'b1, 8'hC0},  // R2 R4 modem: pending, code 0
    {7'b1100000, 7'h7F, 1'b0, 8'h10},  // R3 R5 special char
    {7'b1000000, 7'h7F, 1'b0, 8'h20},  // R3 pin change
    {7'b1111111, 7'h40, 1'b0, 8'h20},  // R6 only lowest prio enabled
    {7'b1111111, 7'h00, 1'b1, 8'hC1},  // R6 R5 all masked
    {7'b0001000, 7'h7F, 1'b1, 8'hC2},  // R1 tx alone
    {7'b0010100, 7'h7F, 1'b1, 8'hCC}   // R1 sparse pattern
  };

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #1;
    chk("R4 reset status", status_o, 8'h01);
    chk("R9 reset irq", {7'd0, irq_o}, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      {req_i, en_i, fifo_en_i} = VEC[v][22:8];
      @(posedge clk_i);
      #1;
      chk($sformatf("R1/R2/R3/R4/R5/R6 vec %0d", v), status_o, VEC[v][7:0]);
      chk($sformatf("R9 vec %0d irq", v), {7'd0, irq_o}, {7'd0, ~VEC[v][0]});
    end

    // R9 latency: no change before the edge, change after it
    @(negedge clk_i);
    req_i = '0; en_i = 7'h7F; fifo_en_i = 1'b1;
    @(posedge clk_i); #1;
    chk("R4 idle fifo on", status_o, 8'hC1);
    @(negedge clk_i);
    req_i = 7'b0001000;
    #1;
    chk("R9 irq before edge", {7'd0, irq_o}, 8'h00);
    @(posedge clk_i); #1;
    chk("R9 irq after edge", {7'd0, irq_o}, 8'h01);
    chk("R2 tx shown", status_o, 8'hC2);
    chk("R8 no clr without read", {1'b0, clr_o}, 8'h00);

    // R7 R8: read strobe and higher-priority arrival in the same cycle
    @(negedge clk_i);
    rd_stb_i = 1'b1;
    req_i = 7'b0001001;
    #1;
    chk("R8 clr tx on read", {1'b0, clr_o}, 8'h08);
    @(posedge clk_i); #1;
    chk("R7 held across read", status_o, 8'hC2);
    @(negedge clk_i);
    rd_stb_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R7 update after read", status_o, 8'hC6);

    // R8: tx still active but not shown -> no clear
    @(negedge clk_i);
    rd_stb_i = 1'b1;
    #1;
    chk("R8 no clr when not shown", {1'b0, clr_o}, 8'h00);
    @(negedge clk_i);
    rd_stb_i = 1'b0;

    // R6: disabling the shown source removes it
    @(negedge clk_i);
    en_i = 7'h7E;
    @(posedge clk_i); #1;
    chk("R6 disabled source dropped", status_o, 8'hC2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule